// File: doc/BRIEF.md
# Index-Driven Scan-Out Shader

This block runs once a frame has been fully resolved: every screen position then holds the index of the triangle that won visibility, and a table holds one parameter set per triangle. On a start pulse the block walks the screen in raster order. For each pixel it reads the stored index and uses it to fetch that triangle's entry. It then produces the final 24-bit colour. No attribute travels with the pixel. Each pixel rebuilds its colour from the single shared entry of its triangle.

Two shading modes exist. Flat mode gives every pixel of a triangle the entry's uniform colour. Gouraud mode evaluates each channel as a plane a·x + b·y + c in signed fixed point, then rounds and clamps the result. A reserved index marks screen positions that no triangle covers, and those pixels take a background colour. Pixels leave on a stream with valid/ready handshake, a frame-start flag and a line-end flag.

The walker is a three-state machine:
- ST_IDLE goes to ST_SCAN on `start`.
- ST_SCAN goes to ST_DRAIN when the last pixel's address is issued.
- ST_DRAIN goes to ST_IDLE once the pipeline holds no pixel.

Top module: `ir_scanout_shader`

## Requirements
- R1: A `start` pulse accepted in idle produces exactly H_RES·V_RES output pixels in raster order, and nothing after them. Pixel (x,y) reads the index buffer at address y·H_RES + x.
- R2: A `start` pulse arriving while a frame is being walked or drained has no effect: no extra pixels, and no restart.
- R3: The index read for a pixel drives `tri_addr`, and the table entry returned there supplies all of that pixel's parameters.
- R4: In flat mode (`mode`=0), a covered pixel outputs bits [23:0] of its entry: red in [23:16], green in [15:8], blue in [7:0].
- R5: In Gouraud mode (`mode`=1), channel k (0=red, 1=green, 2=blue) uses the CW-bit signed fields a, b and c. These sit at bit offsets 24+3k·CW, 24+(3k+1)·CW and 24+(3k+2)·CW. The channel value is (a·x + b·y + c + 2^(FRAC-1)) >>> FRAC, with arithmetic shift, so halves round upward.
- R6: A Gouraud channel result below 0 outputs 0, and one above 255 outputs 255.
- R7: A pixel whose stored index is all ones outputs the background colour in either mode.
- R8: `pix_sof` is high only on the first pixel of a frame. `pix_eol` is high exactly on pixels with x = H_RES-1.
- R9: While `pix_valid` is high and `pix_ready` is low, the output pixel and its flags hold unchanged, and no pixel is lost or duplicated.
- R10: `mode` and `bg_rgb` are sampled when a frame starts. Changes during the frame do not affect it.
- R11: After reset, `pix_valid` is low until a frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a resolved frame |
| mode | input | 1 | 0 = flat, 1 = Gouraud |
| bg_rgb | input | 24 | Background colour for uncovered pixels |
| idx_addr | output | clog2(H_RES·V_RES) | Index buffer read address |
| idx_data | input | IDX_W | Index buffer read data, same cycle |
| tri_addr | output | IDX_W | Triangle table read address |
| tri_data | input | 24+9·CW | Triangle table entry, same cycle |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_sof | output | 1 | First pixel of frame |
| pix_eol | output | 1 | Last pixel of a line |
| pix_rgb | output | 24 | Pixel colour {R,G,B} |

## Verification
Each stage register carries the pixel's coordinates and flags, so a counter or stage slip shows up as a colour taken from a neighbouring pixel's index or position. It also shows as a frame flag or line flag landing on the wrong pixel, which is visible on the first affected pixel, three cycles after its address is issued. A walker that mishandles `start` or the drain shows up as a pixel count other than H_RES·V_RES, or as pixels after the frame. If the mode or background register is not held for the frame, the error appears on the first pixel after the mid-frame input change. A broken stall shows as a changed or missing pixel at the first cycle where ready is low.

// File: rtl/ir_pkg.sv
package ir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } walk_state_t;

    typedef enum logic {
        SHADE_FLAT    = 1'b0,
        SHADE_GOURAUD = 1'b1
    } shade_mode_t;

endpackage

// File: rtl/ir_raster_walk.sv
module ir_raster_walk
    import ir_pkg::*;
#(
    parameter int H_RES = 8,
    parameter int V_RES = 6,
    localparam int XW = (H_RES > 1) ? $clog2(H_RES) : 1,
    localparam int YW = (V_RES > 1) ? $clog2(V_RES) : 1,
    localparam int AW = (H_RES * V_RES > 1) ? $clog2(H_RES * V_RES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_in,
    input  logic [23:0]   bg_in,
    input  logic          adv,
    input  logic          pipe_busy,
    output logic          s0_valid,
    output logic [XW-1:0] s0_x,
    output logic [YW-1:0] s0_y,
    output logic          s0_sof,
    output logic          s0_eol,
    output logic [AW-1:0] s0_addr,
    output logic          mode_q,
    output logic [23:0]   bg_q
);

    walk_state_t st_q, st_d;
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [AW-1:0] addr_q;
    logic          last_px, step;

    assign last_px = (x_q == XW'(H_RES - 1)) && (y_q == YW'(V_RES - 1));
    assign step    = s0_valid && adv;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start)           st_d = ST_SCAN;
            ST_SCAN:  if (step && last_px) st_d = ST_DRAIN;
            ST_DRAIN: if (!pipe_busy)      st_d = ST_IDLE;
            default:                       st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s0_valid = (st_q == ST_SCAN);
        s0_x     = x_q;
        s0_y     = y_q;
        s0_addr  = addr_q;
        s0_sof   = (x_q == '0) && (y_q == '0);
        s0_eol   = (x_q == XW'(H_RES - 1));
    end

    // raster counters and per-frame settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            addr_q <= '0;
            mode_q <= 1'b0;
            bg_q   <= '0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                mode_q <= mode_in;
                bg_q   <= bg_in;
            end
            if (step) begin
                if (last_px) begin
                    x_q    <= '0;
                    y_q    <= '0;
                    addr_q <= '0;
                end else begin
                    addr_q <= addr_q + AW'(1);
                    if (x_q == XW'(H_RES - 1)) begin
                        x_q <= '0;
                        y_q <= y_q + YW'(1);
                    end else begin
                        x_q <= x_q + XW'(1);
                    end
                end
            end
        end
    end

    // R10: frame settings frozen outside idle
    a_r10_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(mode_q) && $stable(bg_q)));

    // R1: linear address tracks the coordinates
    a_r1_addr_linear: assert property (@(posedge clk) disable iff (!rst_n)
        s0_valid |-> (s0_addr == AW'(AW'(y_q) * AW'(H_RES) + AW'(x_q))));

    // R1: last issued pixel ends the walk and rewinds the counters
    a_r1_last_to_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_px) |=> (st_q == ST_DRAIN && x_q == '0 && y_q == '0));

endmodule

// File: rtl/ir_shade_ch.sv
module ir_shade_ch #(
    parameter int CW   = 16,
    parameter int FRAC = 8,
    parameter int XW   = 3,
    parameter int YW   = 3,
    localparam int MW  = (XW > YW) ? XW : YW,
    localparam int AW  = CW + MW + 3
) (
    input  logic signed [CW-1:0] coef_a,
    input  logic signed [CW-1:0] coef_b,
    input  logic signed [CW-1:0] coef_c,
    input  logic [XW-1:0]        x,
    input  logic [YW-1:0]        y,
    output logic [7:0]           chan
);

    localparam logic signed [AW-1:0] RND = AW'(1) <<< (FRAC - 1);
    localparam logic signed [AW-1:0] MAXV = AW'(255);

    logic signed [AW-1:0] ax, by, sum, shifted;

    always_comb begin
        ax      = AW'(coef_a) * AW'($signed({1'b0, x}));
        by      = AW'(coef_b) * AW'($signed({1'b0, y}));
        sum     = ax + by + AW'(coef_c) + RND;
        shifted = sum >>> FRAC;
        if (shifted < 0)         chan = 8'd0;
        else if (shifted > MAXV) chan = 8'd255;
        else                     chan = shifted[7:0];
    end

endmodule

// File: rtl/ir_scanout_shader.sv
module ir_scanout_shader
    import ir_pkg::*;
#(
    parameter int H_RES = 8,
    parameter int V_RES = 6,
    parameter int IDX_W = 4,
    parameter int CW    = 16,
    parameter int FRAC  = 8,
    localparam int XW    = (H_RES > 1) ? $clog2(H_RES) : 1,
    localparam int YW    = (V_RES > 1) ? $clog2(V_RES) : 1,
    localparam int AW    = (H_RES * V_RES > 1) ? $clog2(H_RES * V_RES) : 1,
    localparam int ENT_W = 24 + 9 * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [23:0]      bg_rgb,
    output logic [AW-1:0]    idx_addr,
    input  logic [IDX_W-1:0] idx_data,
    output logic [IDX_W-1:0] tri_addr,
    input  logic [ENT_W-1:0] tri_data,
    output logic             pix_valid,
    input  logic             pix_ready,
    output logic             pix_sof,
    output logic             pix_eol,
    output logic [23:0]      pix_rgb
);

    localparam logic [IDX_W-1:0] NO_TRI = '1;

    logic          adv, pipe_busy;
    logic          s0_valid, s0_sof, s0_eol;
    logic [XW-1:0] s0_x;
    logic [YW-1:0] s0_y;
    logic          mode_q;
    logic [23:0]   bg_q;

    // stage 1: index captured
    logic             s1_valid, s1_sof, s1_eol;
    logic [XW-1:0]    s1_x;
    logic [YW-1:0]    s1_y;
    logic [IDX_W-1:0] s1_idx;

    // stage 2: entry captured
    logic             s2_valid, s2_sof, s2_eol, s2_bg;
    logic [XW-1:0]    s2_x;
    logic [YW-1:0]    s2_y;
    logic [ENT_W-1:0] s2_ent;

    logic [23:0] grd_rgb, shade_rgb;

    assign adv       = !pix_valid || pix_ready;
    assign pipe_busy = s1_valid || s2_valid || pix_valid;
    assign tri_addr  = s1_idx;

    ir_raster_walk #(.H_RES(H_RES), .V_RES(V_RES)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_in  (mode),
        .bg_in    (bg_rgb),
        .adv      (adv),
        .pipe_busy(pipe_busy),
        .s0_valid (s0_valid),
        .s0_x     (s0_x),
        .s0_y     (s0_y),
        .s0_sof   (s0_sof),
        .s0_eol   (s0_eol),
        .s0_addr  (idx_addr),
        .mode_q   (mode_q),
        .bg_q     (bg_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_sof <= 1'b0; s1_eol <= 1'b0;
            s1_x <= '0; s1_y <= '0; s1_idx <= '0;
        end else if (adv) begin
            s1_valid <= s0_valid; s1_sof <= s0_sof; s1_eol <= s0_eol;
            s1_x <= s0_x; s1_y <= s0_y; s1_idx <= idx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0; s2_sof <= 1'b0; s2_eol <= 1'b0; s2_bg <= 1'b0;
            s2_x <= '0; s2_y <= '0; s2_ent <= '0;
        end else if (adv) begin
            s2_valid <= s1_valid; s2_sof <= s1_sof; s2_eol <= s1_eol;
            s2_bg <= (s1_idx == NO_TRI);
            s2_x <= s1_x; s2_y <= s1_y; s2_ent <= tri_data;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_ch
        localparam int BASE = 24 + k * 3 * CW;
        ir_shade_ch #(.CW(CW), .FRAC(FRAC), .XW(XW), .YW(YW)) u_ch (
            .coef_a(s2_ent[BASE +: CW]),
            .coef_b(s2_ent[BASE + CW +: CW]),
            .coef_c(s2_ent[BASE + 2 * CW +: CW]),
            .x     (s2_x),
            .y     (s2_y),
            .chan  (grd_rgb[23 - 8 * k -: 8])
        );
    end

    always_comb begin
        if (s2_bg)                                 shade_rgb = bg_q;
        else if (shade_mode_t'(mode_q) == SHADE_FLAT) shade_rgb = s2_ent[23:0];
        else                                       shade_rgb = grd_rgb;
    end

    // stage 3: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0; pix_sof <= 1'b0; pix_eol <= 1'b0; pix_rgb <= '0;
        end else if (adv) begin
            pix_valid <= s2_valid; pix_sof <= s2_sof; pix_eol <= s2_eol;
            pix_rgb <= shade_rgb;
        end
    end

    // R9: a refused pixel is held
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=>
            (pix_valid && $stable(pix_rgb) && $stable(pix_sof) && $stable(pix_eol)));

    // R7: uncovered pixel leaves with the frame background
    a_r7_bg_out: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s2_valid && s2_bg) |=> (pix_rgb == bg_q));

    // R4: flat pixel leaves with the entry colour
    a_r4_flat_out: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s2_valid && !s2_bg && !mode_q) |=> (pix_rgb == $past(s2_ent[23:0])));

endmodule

// File: tb/tb_ir_scanout_shader.sv
module tb_ir_scanout_shader;

    localparam int CLK_PERIOD = 10;
    localparam int H     = 8;
    localparam int V     = 6;
    localparam int NPIX  = H * V;
    localparam int IDX_W = 4;
    localparam int CW    = 16;
    localparam int FRAC  = 8;
    localparam int ENT_W = 24 + 9 * CW;
    localparam int AW    = $clog2(NPIX);
    localparam int WDOG  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [23:0] bg_rgb = '0;
    logic [AW-1:0] idx_addr;
    logic [IDX_W-1:0] idx_data, tri_addr;
    logic [ENT_W-1:0] tri_data;
    logic pix_valid, pix_sof, pix_eol;
    logic pix_ready = 1'b0;
    logic [23:0] pix_rgb;

    logic [IDX_W-1:0] idx_mem [64];
    logic [ENT_W-1:0] tri_mem [16];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb idx_data = idx_mem[idx_addr];
    always_comb tri_data = tri_mem[tri_addr];

    ir_scanout_shader #(.H_RES(H), .V_RES(V), .IDX_W(IDX_W), .CW(CW), .FRAC(FRAC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bg_rgb(bg_rgb),
        .idx_addr(idx_addr), .idx_data(idx_data), .tri_addr(tri_addr), .tri_data(tri_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_rgb(pix_rgb)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int chan_val(int idx, int k, int x, int y, output bit sat);
        logic signed [CW-1:0] a, b, c;
        longint v;
        int base = 24 + k * 3 * CW;
        a = tri_mem[idx][base +: CW];
        b = tri_mem[idx][base + CW +: CW];
        c = tri_mem[idx][base + 2 * CW +: CW];
        v = longint'(a) * x + longint'(b) * y + longint'(c) + (longint'(1) << (FRAC - 1));
        v = v >>> FRAC;
        sat = (v < 0) || (v > 255);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return int'(v);
    endfunction

    function automatic logic [23:0] exp_rgb(int idx, int x, int y, bit md,
                                            logic [23:0] bg, output bit sat);
        logic [23:0] r;
        bit s;
        sat = 1'b0;
        if (idx == 15) return bg;
        if (!md) return tri_mem[idx][23:0];
        for (int k = 0; k < 3; k++) begin
            r[23 - 8 * k -: 8] = 8'(chan_val(idx, k, x, y, s));
            sat |= s;
        end
        return r;
    endfunction

    function automatic logic [CW-1:0] small_coef();
        return CW'(int'($urandom % 2048) - 1024);
    endfunction

    task automatic fill_tables();
        for (int i = 0; i < 16; i++) begin
            tri_mem[i] = '0;
            tri_mem[i][23:0] = 24'($urandom);
            for (int k = 0; k < 9; k++) begin
                if (i >= 8) tri_mem[i][24 + k * CW +: CW] = CW'($urandom);
                else if (k % 3 == 2) tri_mem[i][24 + k * CW +: CW] = CW'($urandom % 32768);
                else tri_mem[i][24 + k * CW +: CW] = small_coef();
            end
        end
        // entry 0: red saturates high, entry 1: red saturates low
        tri_mem[0][24 +: CW] = 16'h7FFF;
        tri_mem[1][24 + 2 * CW +: CW] = 16'h8000;
        tri_mem[1][24 +: CW] = 16'h0000;
        tri_mem[1][24 + CW +: CW] = 16'h0000;
        // entry 2: rounding of exact halves and just below
        for (int k = 0; k < 9; k++) tri_mem[2][24 + k * CW +: CW] = '0;
        tri_mem[2][24 + 2 * CW +: CW] = 16'h0180;
        tri_mem[2][24 + 5 * CW +: CW] = 16'h017F;
        tri_mem[2][24 + 8 * CW +: CW] = 16'h0080;
        for (int i = 0; i < 64; i++) idx_mem[i] = IDX_W'($urandom % 16);
        idx_mem[0] = 4'hF;
        idx_mem[NPIX - 1] = 4'hF;
        idx_mem[1] = 4'd0;
        idx_mem[2] = 4'd1;
        idx_mem[3] = 4'd2;
        idx_mem[9] = 4'd0;
    endtask

    task automatic run_frame(input bit md, input logic [23:0] bg, input int rdy_pct, input bit inject);
        int n = 0;
        int cyc = 0;
        int extra = 0;
        bit hold = 1'b0;
        logic [23:0] h_rgb;
        logic h_sof, h_eol;
        bit sat;
        logic [23:0] e;
        @(negedge clk);
        mode = md; bg_rgb = bg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < NPIX && cyc < 5000) begin
            cyc++;
            if (hold) begin
                check(pix_valid && pix_rgb == h_rgb && pix_sof == h_sof && pix_eol == h_eol,
                      "R9 held pixel", {7'b0, pix_valid, pix_rgb}, {8'h01, h_rgb});
            end
            if (inject && n == 10) begin
                start = 1'b1; mode = !md; bg_rgb = ~bg;
            end else begin
                start = 1'b0;
            end
            pix_ready = (int'($urandom % 100) < rdy_pct);
            #1;
            if (pix_valid && pix_ready) begin
                int x = n % H;
                int y = n / H;
                int idx = int'(idx_mem[n]);
                e = exp_rgb(idx, x, y, md, bg, sat);
                if (idx == 15)
                    check(pix_rgb == e, inject ? "R7 R10 background" : "R7 background", pix_rgb, e);
                else if (!md)
                    check(pix_rgb == e, inject ? "R3 R4 R10 flat" : "R3 R4 flat", pix_rgb, e);
                else if (sat)
                    check(pix_rgb == e, inject ? "R6 R10 saturate" : "R6 saturate", pix_rgb, e);
                else
                    check(pix_rgb == e, inject ? "R5 R10 plane" : "R5 plane", pix_rgb, e);
                check(pix_sof == (n == 0), "R8 sof", 32'(pix_sof), 32'(n == 0));
                check(pix_eol == (x == H - 1), "R8 eol", 32'(pix_eol), 32'(x == H - 1));
                n++;
            end
            hold = pix_valid && !pix_ready;
            h_rgb = pix_rgb; h_sof = pix_sof; h_eol = pix_eol;
            @(negedge clk);
        end
        start = 1'b0;
        check(n == NPIX, "R1 pixel count", 32'(n), 32'(NPIX));
        pix_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (pix_valid) extra++;
            @(negedge clk);
        end
        check(extra == 0, inject ? "R2 no restart" : "R1 no extra pixels", 32'(extra), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill_tables();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pix_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(pix_valid == 1'b0, "R11 idle after reset", 32'(pix_valid), 32'd0);
        end
        run_frame(1'b0, 24'h123456, 100, 1'b0);
        run_frame(1'b1, 24'hA5C3E1, 60, 1'b0);
        run_frame(1'b1, 24'h0F0F0F, 70, 1'b1);
        fill_tables();
        run_frame(1'b0, 24'hFEDCBA, 40, 1'b1);
        run_frame(1'b1, 24'h00FF00, 30, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule